// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It owns the working register and the step sequencer. An external DAC turns the block's trial code into a voltage. A single comparator then reports whether the sampled input is at or above that voltage. The block works through the bits of the code one clock at a time and builds the converted value from those decisions.

A conversion starts when the start input is high at a rising clock edge while the block is idle. The first cycle after that edge clears the working register. In each of the next n cycles the block drives a trial code to the DAC. The trial code is the bits already decided with the bit under test forced to 1. Bits are tested from the most significant bit down. At the end of each cycle the bit is kept if the comparator input is high and cleared if it is low. After the least significant decision, the block writes the value to the result port and raises done for one cycle. From the accepting edge to the result takes n+1 clock periods, so only n comparisons are needed instead of 2^n.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, and before any start is accepted, done is 0, result is 0 and dac_code is 0.
- R2: start is sampled only at a rising edge while idle. A start seen during a conversion creates no extra conversion and no extra done pulse.
- R3: In the first cycle after the start is accepted, the working register is cleared and dac_code is 0. dac_code is also 0 whenever no bit is under test.
- R4: Bits are tried from the most significant bit to the least significant bit. In the cycle that tests bit k, dac_code holds the bits already decided above k, bit k set to 1, and all bits below k at 0. The first trial code is therefore exactly 1 shifted left by n-1.
- R5: A tested bit is kept when cmp_ge (input at or above the DAC level) is 1 and cleared when it is 0. With an ideal comparator against a target code, result equals the target.
- R6: A conversion contains exactly n trial cycles, one comparison per clock.
- R7: done is high for exactly one cycle. It rises at the edge n+1 clock periods after the edge that accepted start.
- R8: result changes only at the edge that raises done. It holds its value while idle and throughout the following conversion.
- R9: The width n is a parameter from 3 to 16. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_ge | input | 1 | Comparator decision: 1 when the input is at or above the DAC level |
| dac_code | output | WIDTH | Trial code to the external DAC, 0 when no bit is under test |
| done | output | 1 | One-cycle pulse when a new result is written |
| result | output | WIDTH | Last completed conversion value |

## Verification
An ideal comparator model compares dac_code with a target code held in the bench. At width 3 the bench converts every target code. This shows that each bit decision depends only on the target and the bits already decided. At width 8 the bench uses random targets plus all-zeros and all-ones. All-zeros must clear every trial bit, and all-ones must keep every trial bit. Each conversion is compared against an expected trial sequence, the n+1 latency and the final code. A start pulsed in the middle of a conversion must leave the number of done pulses equal to the number of requests.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Legal range of the converter width.
  localparam int SAR_MIN_W = 3;
  localparam int SAR_MAX_W = 16;

  // Phases of one conversion.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLEAR = 2'd1,
    PH_TEST  = 2'd2
  } sar_phase_e;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [IDX_W-1:0] idx,
  output logic             accept_evt,
  output logic             clear_evt,
  output logic             test_evt,
  output logic             last_evt,
  output logic             done
);

  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WIDTH - 1);

  sar_phase_e       phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  // Named events taken from the phase register.
  assign accept_evt = (phase_q == PH_IDLE) && start;
  assign clear_evt  = (phase_q == PH_CLEAR);
  assign test_evt   = (phase_q == PH_TEST);
  assign last_evt   = test_evt && (idx_q == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start) phase_q <= PH_CLEAR;
        end
        PH_CLEAR: begin
          phase_q <= PH_TEST;
          idx_q   <= IDX_TOP;
        end
        PH_TEST: begin
          if (idx_q == '0) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q - IDX_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign idx  = idx_q;
  assign done = done_q;

  AST_CLEAR_THEN_MSB: assert property (@(posedge clk) disable iff (rst)
    clear_evt |=> (test_evt && idx_q == IDX_TOP)); // R3
  AST_IDX_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (test_evt && !last_evt) |=> (test_evt && idx_q == $past(idx_q) - IDX_W'(1))); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (test_evt && !last_evt && start) |=> test_evt); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7
  AST_DONE_AFTER_LSB: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(last_evt)); // R7

endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_evt,
  input  logic             test_evt,
  input  logic [IDX_W-1:0] idx,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] acc_next
);

  logic [WIDTH-1:0] acc_q;

  // One-hot mask for the bit under test.
  function automatic logic [WIDTH-1:0] bit_mask(input logic [IDX_W-1:0] k);
    logic [WIDTH-1:0] m;
    m    = '0;
    m[k] = 1'b1;
    return m;
  endfunction

  // Trial code: decided bits with the tested bit forced high.
  function automatic logic [WIDTH-1:0] trial_of(input logic [WIDTH-1:0] acc,
                                                input logic [IDX_W-1:0] k);
    return acc | bit_mask(k);
  endfunction

  // Decision: keep or drop the tested bit.
  function automatic logic [WIDTH-1:0] decide(input logic [WIDTH-1:0] acc,
                                              input logic [IDX_W-1:0] k,
                                              input logic             keep);
    return keep ? (acc | bit_mask(k)) : (acc & ~bit_mask(k));
  endfunction

  assign dac_code = test_evt ? trial_of(acc_q, idx) : '0;
  assign acc_next = decide(acc_q, idx, cmp_ge);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      acc_q <= '0;
    end else if (clear_evt) begin
      acc_q <= '0;
    end else if (test_evt) begin
      acc_q <= acc_next;
    end
  end

  AST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clear_evt |=> (acc_q == '0)); // R3
  AST_KEEP_GE: assert property (@(posedge clk) disable iff (rst)
    (test_evt && cmp_ge) |=> acc_q[$past(idx)]); // R5
  AST_DROP_LT: assert property (@(posedge clk) disable iff (rst)
    (test_evt && !cmp_ge) |=> !acc_q[$past(idx)]); // R5
  AST_ONE_TRIAL_BIT: assert property (@(posedge clk) disable iff (rst)
    test_evt |-> ($countones(dac_code ^ acc_q) == 1)); // R4

endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             last_evt,
  input  logic [WIDTH-1:0] acc_next,
  output logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] result_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      result_q <= '0;
    end else if (last_evt) begin
      result_q <= acc_next;
    end
  end

  assign result = result_q;

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !last_evt |=> $stable(result_q)); // R8

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] dac_code,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  localparam int IDX_W = $clog2(WIDTH);

  // R9: reject widths outside the supported range.
  if (WIDTH < SAR_MIN_W || WIDTH > SAR_MAX_W) begin : g_bad_width
    $error("sar_conv_ctrl: WIDTH out of range");
  end

  logic [IDX_W-1:0] idx;
  logic             accept_evt;
  logic             clear_evt;
  logic             test_evt;
  logic             last_evt;
  logic [WIDTH-1:0] acc_next;

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .idx        (idx),
    .accept_evt (accept_evt),
    .clear_evt  (clear_evt),
    .test_evt   (test_evt),
    .last_evt   (last_evt),
    .done       (done)
  );

  sar_reg #(.WIDTH(WIDTH)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .clear_evt (clear_evt),
    .test_evt  (test_evt),
    .idx       (idx),
    .cmp_ge    (cmp_ge),
    .dac_code  (dac_code),
    .acc_next  (acc_next)
  );

  sar_result #(.WIDTH(WIDTH)) u_res (
    .clk      (clk),
    .rst      (rst),
    .last_evt (last_evt),
    .acc_next (acc_next),
    .result   (result)
  );

  AST_ACCEPT_TO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> clear_evt); // R2
  AST_IDLE_DAC_ZERO: assert property (@(posedge clk) disable iff (rst)
    !test_evt |-> (dac_code == '0)); // R3
  AST_NO_DONE_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear_evt |-> !done); // R7

endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sar_lane_tb #(
  parameter int W       = 3,
  parameter bit EXHAUST = 1'b1,
  parameter int NRAND   = 0
) (
  input  logic clk,
  input  logic rst,
  output int   n_chk,
  output int   n_err,
  output logic fin
);

  logic         start;
  logic [W-1:0] target;
  logic [W-1:0] dac_code;
  logic [W-1:0] result;
  logic         done;
  logic         cmp_ge;

  // Ideal DAC plus comparator.
  assign cmp_ge = (target >= dac_code);

  sar_conv_ctrl #(.WIDTH(W)) u0 (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cmp_ge   (cmp_ge),
    .dac_code (dac_code),
    .done     (done),
    .result   (result)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard queues.
  int tq[$];
  int sq[$];
  bit busy = 1'b0;
  int done_seen = 0;
  int pushes = 0;
  int cur_t, cur_s, trials;
  bit trial_ok, clear_ok, hold_ok;
  int last_res = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (W=%0d) actual=%0d expected=%0d", req, W, act, exp);
    end
  endtask

  // Monitor: follows each conversion and pops the expected value on done.
  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !done) begin
        int rel;
        rel = cyc - cur_s;
        if (int'(result) != last_res) hold_ok = 1'b0;
        if (rel == 0) begin
          if (dac_code != '0) clear_ok = 1'b0;
        end else if (rel >= 1 && rel <= W) begin
          int k, e;
          k = W - rel;
          e = ((cur_t >> (k + 1)) << (k + 1)) | (1 << k);
          if (int'(dac_code) != e) trial_ok = 1'b0;
          if (dac_code != '0) trials++;
        end
      end
      if (done) begin
        done_seen++;
        if (tq.size() == 0) begin
          chk(1'b0, "R2 unexpected done", 1, 0);
        end else begin
          int t, s;
          t = tq.pop_front();
          s = sq.pop_front();
          chk(int'(result) == t, "R5 result", int'(result), t);
          chk(cyc - s == W + 1, "R7 latency", cyc - s, W + 1);
          chk(trial_ok, "R4 trial sequence", int'(trial_ok), 1);
          chk(clear_ok, "R3 clear cycle dac", int'(clear_ok), 1);
          chk(trials == W, "R6 trial count", trials, W);
          chk(hold_ok, "R8 hold during conversion", int'(hold_ok), 1);
          last_res = int'(result);
          busy = 1'b0;
        end
      end
    end
  end

  // Driver: pushes the expectation and requests a conversion.
  task automatic convert(input logic [W-1:0] t, input int extra);
    wait (!busy);
    @(negedge clk);
    target   = t;
    cur_t    = int'(t);
    cur_s    = cyc + 1;
    trials   = 0;
    trial_ok = 1'b1;
    clear_ok = 1'b1;
    hold_ok  = 1'b1;
    tq.push_back(int'(t));
    sq.push_back(cyc + 1);
    pushes++;
    busy  = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra > 0) begin
      repeat (extra - 1) @(negedge clk);
      start = 1'b1;  // R2: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    wait (!busy);
    @(negedge clk);
    chk(!done, "R7 done single cycle", int'(done), 0);
  endtask

  initial begin
    n_chk  = 0;
    n_err  = 0;
    fin    = 1'b0;
    start  = 1'b0;
    target = '0;
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(result == '0, "R1 reset result", int'(result), 0);
    chk(dac_code == '0, "R1 reset dac_code", int'(dac_code), 0);
    wait (!rst);
    @(negedge clk);
    @(negedge clk);
    chk(dac_code == '0 && !done, "R1 idle after reset", int'(dac_code), 0);

    if (EXHAUST) begin
      for (int t = 0; t < (1 << W); t++) convert(W'(t), 0);
    end
    convert('1, 0);
    convert('0, 0);
    for (int i = 0; i < NRAND; i++) convert(W'($urandom_range(0, (1 << W) - 1)), 0);

    // R2: starts pulsed mid-conversion.
    convert(W'(5), 2);
    convert(W'((1 << W) - 2), W - 1);

    // R8: result holds while idle.
    begin
      bit stable_ok;
      stable_ok = 1'b1;
      repeat (6) begin
        @(negedge clk);
        if (int'(result) != last_res || done) stable_ok = 1'b0;
      end
      chk(stable_ok, "R8 hold while idle", int'(result), last_res);
    end
    chk(done_seen == pushes, "R2 done count", done_seen, pushes);
    fin = 1'b1;
  end

endmodule

module sim_sar_conv_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  bit   timeout = 1'b0;

  int   c3, e3, c8, e8;
  logic f3, f8;

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
  end

  // R9 lanes: exhaustive at the smallest width, random at eight bits.
  sar_lane_tb #(.W(3), .EXHAUST(1'b1), .NRAND(0)) lane3 (
    .clk(clk), .rst(rst), .n_chk(c3), .n_err(e3), .fin(f3)
  );
  sar_lane_tb #(.W(8), .EXHAUST(1'b0), .NRAND(60)) lane8 (
    .clk(clk), .rst(rst), .n_chk(c8), .n_err(e8), .fin(f8)
  );

  initial begin
    repeat (100000) @(posedge clk);
    timeout = 1'b1;
  end

  initial begin
    int errs, total;
    wait ((f3 === 1'b1 && f8 === 1'b1) || timeout);
    errs  = e3 + e8;
    total = c3 + c8;
    if (timeout) begin
      errs++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule